// File: doc/BRIEF.md
# Console Service Trap Monitor

A verification-side unit that sits next to an 8-bit processor model with a flat 64 KB address space. The model reports each retired instruction together with the program counter that follows it and a few register values. When that program counter equals the fixed service entry 0x0005, the unit takes over. It holds the processor and reads the function selector from register C. For the single-character service it sends the byte from register E to a byte stream. For the string service it reads memory from the address in register pair DE and streams each byte until it meets the terminator `$` (0x24). It then synthesizes a subroutine return: it reads a little-endian word from the stack and hands back a new PC and SP on an update port.

A program counter of 0x0000 after a retirement marks the end of the program. The unit raises a sticky completion flag and withdraws the processor's advance enable. An unknown selector raises a sticky error and also withdraws the enable. Before a run the harness places the program at 0x0100, with PC = 0x0100 and SP = 0xF000. The unit has no part in that loading step.

Top module: `conio_trap_monitor`

## Requirements
- R1: A cycle with `retire_valid` high and `retire_pc` = 0x0005 is a service trap. `cpu_stall` is high from that cycle up to and including the cycle in which `upd_valid` pulses, and low in the cycle after.
- R2: A cycle with `retire_valid` high and `retire_pc` = 0x0000 sets `done` from the next cycle on. `done` stays set until reset, and `cpu_run_en` is low while it is set.
- R3: Selector 0x02 in `reg_c` sends the value of `reg_e` exactly once on `out_data`.
- R4: Selector 0x09 sends the bytes at DE, DE+1, ... in ascending address order. Sending stops at the first byte equal to 0x24, which is not sent. If the first byte is 0x24, nothing is sent.
- R5: The string read address wraps from 0xFFFF to 0x0000.
- R6: Each completed service ends with one single-cycle `upd_valid` pulse. In that pulse `upd_pc` = {mem[SP+1], mem[SP]} (low byte at SP) and `upd_sp` = SP + 2 modulo 0x10000, where SP is `reg_sp` in the trap cycle.
- R7: A byte moves when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` is held. No byte is lost or repeated under backpressure.
- R8: Any selector other than 0x02 or 0x09 sets a sticky `err` and drops `cpu_run_en`. No byte is sent and no `upd_valid` pulse occurs.
- R9: A retirement at any other PC, and a PC of 0x0005 without `retire_valid`, leave `cpu_stall` low. They cause no memory read and no output.
- R10: `mem_rd_data` is taken one cycle after `mem_rd_en`. Reads happen only while `cpu_stall` is high. A string of N visible bytes costs N+1 string reads plus 2 stack reads.
- R11: After reset, `out_valid`, `upd_valid`, `mem_rd_en`, `cpu_stall`, `done` and `err` are low and `cpu_run_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | An instruction retired this cycle |
| retire_pc | input | 16 | Program counter after the retired instruction |
| reg_c | input | 8 | Service selector register |
| reg_e | input | 8 | Character for the single-character service |
| reg_de | input | 16 | String start address |
| reg_sp | input | 16 | Stack pointer |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, one cycle after the strobe |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Sink accepts the byte |
| upd_valid | output | 1 | Return update pulse |
| upd_pc | output | 16 | New program counter |
| upd_sp | output | 16 | New stack pointer |
| cpu_stall | output | 1 | Hold the processor |
| cpu_run_en | output | 1 | Processor may advance |
| done | output | 1 | Program finished (sticky) |
| err | output | 1 | Unknown service selector (sticky) |

## Verification
The checker assumes that the processor side never reports a retirement in a cycle after `cpu_stall` was high. It also assumes that read data comes back exactly one cycle after each strobe, with no other reads in flight. The bench acts as the processor. It raises `retire_valid` for a single cycle and then waits for the update pulse before it does anything else. Its memory model answers every strobe one cycle later from a sparse byte array. Backpressure is applied only through `out_ready`, which the bench is free to toggle at any time.

// File: rtl/conio_trap_pkg.sv
package conio_trap_pkg;
  typedef enum logic [1:0] {
    FK_CHAR,
    FK_STR,
    FK_BAD
  } fn_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EMIT,
    ST_WAIT,
    ST_SRD,
    ST_SDAT,
    ST_RLO,
    ST_RHI,
    ST_UPD
  } seq_state_e;
endpackage

// File: rtl/conio_trap_decode.sv
module conio_trap_decode
  import conio_trap_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter int unsigned       DATA_W  = 8,
  parameter logic [ADDR_W-1:0] SVC_PC  = 'h0005,
  parameter logic [ADDR_W-1:0] EXIT_PC = 'h0000,
  parameter logic [DATA_W-1:0] FN_CHAR = 'h02,
  parameter logic [DATA_W-1:0] FN_STR  = 'h09
) (
  input  logic              retire_valid,
  input  logic [ADDR_W-1:0] retire_pc,
  input  logic [DATA_W-1:0] fn_code,
  output logic              trap_hit,
  output logic              exit_hit,
  output fn_kind_e          fn_kind
);
  always_comb begin
    trap_hit = retire_valid && (retire_pc == SVC_PC);
    exit_hit = retire_valid && (retire_pc == EXIT_PC);
    if (fn_code == FN_CHAR)     fn_kind = FK_CHAR;
    else if (fn_code == FN_STR) fn_kind = FK_STR;
    else                        fn_kind = FK_BAD;
  end
endmodule

// File: rtl/conio_out_stage.sv
module conio_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    data_en = 1'b0;
    if (push) begin
      valid_d = 1'b1;
      data_d  = push_data;
      data_en = 1'b1;
    end else if (valid_q && out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/conio_trap_seq.sv
module conio_trap_seq
  import conio_trap_pkg::*;
#(
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] TERM   = 'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_hit,
  input  logic              exit_hit,
  input  fn_kind_e          fn_kind,
  input  logic [DATA_W-1:0] reg_e,
  input  logic [ADDR_W-1:0] reg_de,
  input  logic [ADDR_W-1:0] reg_sp,
  input  logic              stage_busy,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              upd_valid,
  output logic [ADDR_W-1:0] upd_pc,
  output logic [ADDR_W-1:0] upd_sp,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int unsigned       WORD_W   = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_TWO = ADDR_W'(2);

  seq_state_e        state_q, state_d;
  logic              is_str_q, is_str_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              ctx_en;

  always_comb begin
    state_d     = state_q;
    is_str_d    = is_str_q;
    ptr_d       = ptr_q;
    sp_d        = sp_q;
    byte_d      = byte_q;
    lo_d        = lo_q;
    done_d      = done_q;
    err_d       = err_q;
    ctx_en      = 1'b0;
    push        = 1'b0;
    mem_rd_en   = 1'b0;
    mem_rd_addr = ptr_q;
    upd_valid   = 1'b0;
    upd_pc      = ADDR_W'({mem_rd_data, lo_q});
    upd_sp      = sp_q + ADDR_TWO;

    unique case (state_q)
      ST_IDLE: begin
        if (exit_hit) done_d = 1'b1;
        if (trap_hit) begin
          ctx_en   = 1'b1;
          ptr_d    = reg_de;
          sp_d     = reg_sp;
          byte_d   = reg_e;
          is_str_d = (fn_kind == FK_STR);
          unique case (fn_kind)
            FK_CHAR: state_d = ST_EMIT;
            FK_STR:  state_d = ST_SRD;
            default: err_d   = 1'b1;
          endcase
        end
      end
      ST_EMIT: begin
        push    = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (stage_busy && out_ready) begin
          if (is_str_q) begin
            ptr_d   = ptr_q + ADDR_ONE;
            state_d = ST_SRD;
          end else begin
            state_d = ST_RLO;
          end
        end
      end
      ST_SRD: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = ptr_q;
        state_d     = ST_SDAT;
      end
      ST_SDAT: begin
        if (mem_rd_data == TERM) begin
          state_d = ST_RLO;
        end else begin
          byte_d  = mem_rd_data;
          state_d = ST_EMIT;
        end
      end
      ST_RLO: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = sp_q;
        state_d     = ST_RHI;
      end
      ST_RHI: begin
        lo_d        = mem_rd_data;
        mem_rd_en   = 1'b1;
        mem_rd_addr = sp_q + ADDR_ONE;
        state_d     = ST_UPD;
      end
      ST_UPD: begin
        upd_valid = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      is_str_q <= 1'b0;
      ptr_q    <= '0;
      sp_q     <= '0;
      byte_q   <= '0;
      lo_q     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      ptr_q   <= ptr_d;
      byte_q  <= byte_d;
      lo_q    <= lo_d;
      if (ctx_en) begin
        is_str_q <= is_str_d;
        sp_q     <= sp_d;
      end
    end
  end

  assign push_data = byte_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  if (WORD_W < ADDR_W) begin : g_narrow_word
    initial $error("stack word narrower than address");
  end
endmodule

// File: rtl/conio_trap_monitor.sv
module conio_trap_monitor
  import conio_trap_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter int unsigned       DATA_W  = 8,
  parameter logic [ADDR_W-1:0] SVC_PC  = 'h0005,
  parameter logic [ADDR_W-1:0] EXIT_PC = 'h0000,
  parameter logic [DATA_W-1:0] FN_CHAR = 'h02,
  parameter logic [DATA_W-1:0] FN_STR  = 'h09,
  parameter logic [DATA_W-1:0] TERM    = 'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_valid,
  input  logic [ADDR_W-1:0] retire_pc,
  input  logic [DATA_W-1:0] reg_c,
  input  logic [DATA_W-1:0] reg_e,
  input  logic [ADDR_W-1:0] reg_de,
  input  logic [ADDR_W-1:0] reg_sp,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              upd_valid,
  output logic [ADDR_W-1:0] upd_pc,
  output logic [ADDR_W-1:0] upd_sp,
  output logic              cpu_stall,
  output logic              cpu_run_en,
  output logic              done,
  output logic              err
);
  logic              trap_hit;
  logic              exit_hit;
  fn_kind_e          fn_kind;
  logic              push;
  logic [DATA_W-1:0] push_data;
  logic              busy;

  conio_trap_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SVC_PC (SVC_PC),
    .EXIT_PC(EXIT_PC),
    .FN_CHAR(FN_CHAR),
    .FN_STR (FN_STR)
  ) decode_i (
    .retire_valid(retire_valid),
    .retire_pc   (retire_pc),
    .fn_code     (reg_c),
    .trap_hit    (trap_hit),
    .exit_hit    (exit_hit),
    .fn_kind     (fn_kind)
  );

  conio_trap_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .TERM  (TERM)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_hit   (trap_hit),
    .exit_hit   (exit_hit),
    .fn_kind    (fn_kind),
    .reg_e      (reg_e),
    .reg_de     (reg_de),
    .reg_sp     (reg_sp),
    .stage_busy (out_valid),
    .out_ready  (out_ready),
    .mem_rd_data(mem_rd_data),
    .push       (push),
    .push_data  (push_data),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_sp     (upd_sp),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  conio_out_stage #(
    .DATA_W(DATA_W)
  ) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(push_data),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  assign cpu_stall  = busy | trap_hit;
  assign cpu_run_en = ~(done | err);
endmodule

// File: rtl/conio_trap_monitor_chk.sv
module conio_trap_monitor_chk #(
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_PC = 'h0005
) (
  input logic              clk,
  input logic              rst_n,
  input logic              retire_valid,
  input logic [ADDR_W-1:0] retire_pc,
  input logic              mem_rd_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              upd_valid,
  input logic              cpu_stall,
  input logic              cpu_run_en,
  input logic              done,
  input logic              err
);
  // Input contract: no retirement right after a stalled cycle.
  a_r1_no_retire_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> !$past(cpu_stall));

  a_r1_trap_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_pc == SVC_PC) |-> cpu_stall);

  a_r6_upd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (!upd_valid && !cpu_stall));

  a_r6_upd_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> cpu_stall);

  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r8_run_en_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !cpu_run_en);

  a_r10_reads_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> cpu_stall);

  a_r9_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    ((!retire_valid || retire_pc != SVC_PC) && !$past(cpu_stall)) |-> !cpu_stall);
endmodule

bind conio_trap_monitor conio_trap_monitor_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .SVC_PC(SVC_PC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .retire_valid(retire_valid),
  .retire_pc   (retire_pc),
  .mem_rd_en   (mem_rd_en),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_ready   (out_ready),
  .upd_valid   (upd_valid),
  .cpu_stall   (cpu_stall),
  .cpu_run_en  (cpu_run_en),
  .done        (done),
  .err         (err)
);

// File: tb/conio_trap_monitor_tb_top.sv
module conio_trap_monitor_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_valid;
  logic [15:0] retire_pc;
  logic [7:0]  reg_c, reg_e;
  logic [15:0] reg_de, reg_sp;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready;
  logic        upd_valid;
  logic [15:0] upd_pc, upd_sp;
  logic        cpu_stall, cpu_run_en, done, err;

  int unsigned tests_run = 0;
  int unsigned tests_failed = 0;
  bit          finished = 1'b0;
  bit          bp_mode = 1'b0;
  int unsigned cyc = 0;
  int unsigned rd_cnt = 0;
  int unsigned upd_cnt = 0;
  logic [7:0]  mem [int unsigned];
  logic [7:0]  got [$];
  logic [15:0] seen_pc, seen_sp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  conio_trap_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .reg_c(reg_c), .reg_e(reg_e), .reg_de(reg_de), .reg_sp(reg_sp),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_sp(upd_sp),
    .cpu_stall(cpu_stall), .cpu_run_en(cpu_run_en), .done(done), .err(err)
  );

  function automatic logic [7:0] rd_mem(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  // Memory model: one-cycle read latency; output collector; counters.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) begin
      mem_rd_data <= rd_mem(mem_rd_addr);
      rd_cnt <= rd_cnt + 1;
    end
    if (rst_n && out_valid && out_ready) got.push_back(out_data);
    if (rst_n && upd_valid) upd_cnt <= upd_cnt + 1;
  end

  always @(negedge clk) out_ready <= bp_mode ? (cyc % 3 == 0) : 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    retire_valid = 1'b0;
    retire_pc = 16'h0100;
    reg_c = '0; reg_e = '0; reg_de = '0; reg_sp = 16'hF000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put_str(input logic [15:0] a, input string s);
    for (int i = 0; i < s.len(); i++) mem[int'(a + 16'(i))] = s[i];
  endtask

  // One service call; returns when the update pulse has been seen.
  task automatic run_call(input logic [7:0] c, input logic [7:0] e,
                          input logic [15:0] de, input logic [15:0] sp);
    bit seen = 1'b0;
    got.delete();
    @(negedge clk);
    retire_valid = 1'b1; retire_pc = 16'h0005;
    reg_c = c; reg_e = e; reg_de = de; reg_sp = sp;
    #1;
    chk(cpu_stall == 1'b1, "R1", "stall in trap cycle", cpu_stall, 1);
    @(negedge clk);
    retire_valid = 1'b0; retire_pc = 16'h0100;
    for (int k = 0; k < 2000 && !seen; k++) begin
      if (!cpu_stall) begin
        chk(1'b0, "R1", "stall dropped early", 0, 1);
        break;
      end
      if (upd_valid) begin
        seen = 1'b1;
        seen_pc = upd_pc;
        seen_sp = upd_sp;
      end
      @(negedge clk);
    end
    chk(seen, "R6", "update pulse seen", seen, 1);
    chk(cpu_stall == 1'b0 && upd_valid == 1'b0, "R1", "released after update",
        {cpu_stall, upd_valid}, 0);
  endtask

  task automatic chk_got(input string req, input string s);
    chk(got.size() == s.len(), req, "byte count", got.size(), s.len());
    for (int i = 0; i < s.len() && i < got.size(); i++)
      chk(got[i] == s[i], req, "byte value", got[i], s[i]);
  endtask

  task automatic t_reset();
    chk(!out_valid && !upd_valid && !mem_rd_en && !cpu_stall && !done && !err && cpu_run_en,
        "R11", "reset outputs",
        {out_valid, upd_valid, mem_rd_en, cpu_stall, done, err, cpu_run_en}, 1);
  endtask

  task automatic t_char();
    mem[32'hEFFE] = 8'h34; mem[32'hEFFF] = 8'h12;
    run_call(8'h02, 8'h41, 16'h0000, 16'hEFFE);
    chk_got("R3", "A");
    chk(seen_pc == 16'h1234, "R6", "return pc", seen_pc, 16'h1234);
    chk(seen_sp == 16'hF000, "R6", "return sp", seen_sp, 16'hF000);
    // Character service may send the terminator value itself; SP wraps.
    mem[32'hFFFE] = 8'hCD; mem[32'hFFFF] = 8'hAB;
    run_call(8'h02, 8'h24, 16'h0000, 16'hFFFE);
    chk_got("R3", "$");
    chk(seen_pc == 16'hABCD, "R6", "return pc at top", seen_pc, 16'hABCD);
    chk(seen_sp == 16'h0000, "R6", "sp wraps", seen_sp, 16'h0000);
  endtask

  task automatic t_string();
    int unsigned r0;
    mem[32'hEFFE] = 8'h00; mem[32'hEFFF] = 8'h02;
    put_str(16'h0300, "HI$Z");
    bp_mode = 1'b1;
    r0 = rd_cnt;
    run_call(8'h09, 8'h00, 16'h0300, 16'hEFFE);
    bp_mode = 1'b0;
    chk_got("R4", "HI");
    chk_got("R7", "HI");
    chk(rd_cnt - r0 == 5, "R10", "read count", rd_cnt - r0, 5);
    chk(seen_pc == 16'h0200, "R6", "string return pc", seen_pc, 16'h0200);
    put_str(16'h0400, "hello, world$");
    bp_mode = 1'b1;
    run_call(8'h09, 8'h00, 16'h0400, 16'hEFFE);
    bp_mode = 1'b0;
    chk_got("R7", "hello, world");
  endtask

  task automatic t_wrap();
    mem[32'hEFFE] = 8'h10; mem[32'hEFFF] = 8'h01;
    put_str(16'hFFFE, "xy");
    put_str(16'h0000, "z$");
    run_call(8'h09, 8'h00, 16'hFFFE, 16'hEFFE);
    chk_got("R5", "xyz");
    chk(seen_pc == 16'h0110, "R6", "wrap return pc", seen_pc, 16'h0110);
  endtask

  task automatic t_empty();
    int unsigned r0;
    put_str(16'h0500, "$");
    r0 = rd_cnt;
    run_call(8'h09, 8'h00, 16'h0500, 16'hEFFE);
    chk(got.size() == 0, "R4", "empty string sends nothing", got.size(), 0);
    chk(rd_cnt - r0 == 3, "R10", "empty read count", rd_cnt - r0, 3);
  endtask

  task automatic t_nontrap();
    int unsigned r0 = rd_cnt;
    int unsigned u0 = upd_cnt;
    got.delete();
    @(negedge clk);
    retire_valid = 1'b1; retire_pc = 16'h0123; reg_c = 8'h02;
    #1;
    chk(!cpu_stall, "R9", "other pc no stall", cpu_stall, 0);
    @(negedge clk);
    retire_valid = 1'b0; retire_pc = 16'h0005;
    #1;
    chk(!cpu_stall, "R9", "pc 5 without retire", cpu_stall, 0);
    repeat (6) @(negedge clk);
    retire_pc = 16'h0100;
    chk(rd_cnt == r0 && upd_cnt == u0 && got.size() == 0 && !cpu_stall, "R9",
        "no activity", rd_cnt - r0 + upd_cnt - u0 + got.size(), 0);
  endtask

  task automatic t_done();
    @(negedge clk);
    chk(!done, "R2", "done before exit", done, 0);
    retire_valid = 1'b1; retire_pc = 16'h0000;
    @(negedge clk);
    retire_valid = 1'b0; retire_pc = 16'h0100;
    chk(done && !cpu_run_en, "R2", "done set, run off", {done, cpu_run_en}, 2'b10);
    repeat (4) @(negedge clk);
    chk(done, "R2", "done sticky", done, 1);
  endtask

  task automatic t_bad();
    int unsigned u0 = upd_cnt;
    got.delete();
    @(negedge clk);
    retire_valid = 1'b1; retire_pc = 16'h0005; reg_c = 8'h07; reg_e = 8'h55;
    @(negedge clk);
    retire_valid = 1'b0; retire_pc = 16'h0100;
    chk(err && !cpu_run_en, "R8", "err set, run off", {err, cpu_run_en}, 2'b10);
    repeat (8) @(negedge clk);
    chk(err && got.size() == 0 && upd_cnt == u0, "R8", "sticky, silent",
        {err, 8'(got.size())}, 9'h100);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_char();
    t_string();
    t_wrap();
    t_empty();
    t_nontrap();
    t_done();
    do_reset();
    t_reset();
    t_bad();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule